// File: doc/BRIEF.md
# Auxiliary Register Address Unit

This block keeps a bank of eight 16-bit address registers and a 3-bit pointer that picks the active one. The active register's value is presented as the data-memory operand address. When a command asks for it, the register is then post-modified: it may step by one, step by an index value, take a reverse-carry index step for FFT reordering, or wrap inside one of two circular buffers. The same unit also adds or subtracts a short immediate, compares the active register against a reference, and changes the pointer while keeping the old pointer in a backup field.

A decoder drives one command per cycle on `cmd`, with a post-modify code on `mode`. Index, compare reference and circular buffer bounds arrive as plain inputs from the registers that own them. A separate load port writes any register directly. All register state changes on the rising clock edge. The address output is combinational from the current state, so it always shows the value before that cycle's update.

Top module: `aux_addr_unit`

## Requirements
- R1: Synchronous active-high reset clears all eight registers, the pointer, the backup pointer and the test flag to zero.
- R2: `addr_out` equals the value of the register selected by the pointer. During an access cycle it shows the value before the update, and the modified value appears only after the next rising edge.
- R3: For an access (`cmd`=1), mode 1 adds one and mode 2 subtracts one from the active register, modulo 2^16.
- R4: Mode 3 adds `idx_val` and mode 4 subtracts `idx_val` from the active register, modulo 2^16.
- R5: Mode 5 adds `idx_val` with the carry running from bit 15 toward bit 0. Mode 6 subtracts `idx_val` with the borrow running the same way. Both results wrap.
- R6: `cmd`=2 adds and `cmd`=3 subtracts the zero-extended 8-bit `imm` to or from the active register, modulo 2^16.
- R7: `cmd`=4 loads `new_ptr` into the pointer and copies the previous pointer into `ptr_bak`. The registers do not change.
- R8: `cmd`=5 sets `tc_flag` to the result of an unsigned comparison between the active register and `cmp_val`, selected by `cmp_sel`: 0 equal, 1 less than, 2 greater than, 3 not equal. Any other command leaves `tc_flag` unchanged.
- R9: `circ_ctrl` bit 3 enables buffer 0 and bits 2:0 name the register it governs. Bit 7 enables buffer 1 and bits 6:4 name its register. On any modification (access modes 1 to 6, `cmd` 2 or 3), if the active register is governed by an enabled buffer and equals that buffer's end value, it is reloaded with that buffer's start value. Otherwise the normal result applies. Buffer 0 takes precedence when both match.
- R10: When `ld_en` is high, register `ld_sel` takes `ld_val` at the next edge. This takes priority over a modification of the same register in that cycle. A modification of a different register still happens.
- R11: Access modes 0 and 7, and `cmd` 0, 6 and 7, leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command: 0 idle, 1 access, 2 add imm, 3 sub imm, 4 pointer change, 5 compare |
| mode | input | 3 | Post-modify code for access |
| imm | input | 8 | Short unsigned immediate |
| new_ptr | input | 3 | Pointer value for pointer change |
| idx_val | input | 16 | Index step value |
| cmp_val | input | 16 | Compare reference |
| cmp_sel | input | 2 | Compare relation code |
| circ_ctrl | input | 8 | Circular buffer enables and register selects |
| buf0_start | input | 16 | Buffer 0 start |
| buf0_end | input | 16 | Buffer 0 end |
| buf1_start | input | 16 | Buffer 1 start |
| buf1_end | input | 16 | Buffer 1 end |
| ld_en | input | 1 | Direct load enable |
| ld_sel | input | 3 | Direct load target register |
| ld_val | input | 16 | Direct load value |
| addr_out | output | 16 | Operand address (active register) |
| tc_flag | output | 1 | Compare result flag |
| ptr_out | output | 3 | Current pointer |
| ptr_bak | output | 3 | Backup of previous pointer |
| ar_flat | output | 128 | All registers, register n in bits 16n+15:16n |

## Verification
All register state is visible on `ar_flat`, the pointer is visible on `ptr_out` and `ptr_bak`, and the flag is visible on `tc_flag`. A wrong step, a wrong wrap decision or an update to the wrong register therefore shows up one cycle after the offending command. An update that lands too early breaks the pre-update value on `addr_out` in the same cycle. A reverse-carry error only shows on index patterns whose carry crosses bits, so the sweep uses indices of one bit, of all bits, and of the top bit only.

// File: rtl/aux_addr_pkg.sv
package aux_addr_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_ACCESS = 3'd1,
        CMD_ADDK   = 3'd2,
        CMD_SUBK   = 3'd3,
        CMD_SETPTR = 3'd4,
        CMD_CMP    = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        MOD_NONE  = 3'd0,
        MOD_INC   = 3'd1,
        MOD_DEC   = 3'd2,
        MOD_IADD  = 3'd3,
        MOD_ISUB  = 3'd4,
        MOD_RADD  = 3'd5,
        MOD_RSUB  = 3'd6,
        MOD_NONE2 = 3'd7
    } mod_e;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_LT = 2'd1,
        CMP_GT = 2'd2,
        CMP_NE = 2'd3
    } cmp_e;

endpackage

// File: rtl/aux_circ.sv
module aux_circ #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 3,
    localparam int FLD_W = PTR_W + 1,
    localparam int CTL_W = 2 * FLD_W
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DATA_W-1:0] cur,
    input  logic [CTL_W-1:0]  ctrl,
    input  logic [DATA_W-1:0] start0,
    input  logic [DATA_W-1:0] end0,
    input  logic [DATA_W-1:0] start1,
    input  logic [DATA_W-1:0] end1,
    output logic              hit,
    output logic [DATA_W-1:0] wrap_to
);
    logic [1:0] match;
    logic [DATA_W-1:0] ends [2];

    assign ends[0] = end0;
    assign ends[1] = end1;

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic             en;
        logic [PTR_W-1:0] sel;
        assign en  = ctrl[b*FLD_W + PTR_W];
        assign sel = ctrl[b*FLD_W +: PTR_W];
        assign match[b] = en && (sel == ptr) && (cur == ends[b]);
    end

    assign hit     = |match;
    assign wrap_to = match[0] ? start0 : start1;
endmodule

// File: rtl/aux_step.sv
module aux_step
    import aux_addr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 8
) (
    input  cmd_e              cmd,
    input  mod_e              mode,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] idx,
    input  logic [IMM_W-1:0]  imm,
    input  logic              wrap_hit,
    input  logic [DATA_W-1:0] wrap_to,
    output logic              upd,
    output logic [DATA_W-1:0] nxt
);
    logic [DATA_W-1:0] cur_r, idx_r, rsum, rdif, rsum_r, rdif_r, imm_z, calc;

    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign cur_r[i]  = cur[DATA_W-1-i];
        assign idx_r[i]  = idx[DATA_W-1-i];
        assign rsum_r[i] = rsum[DATA_W-1-i];
        assign rdif_r[i] = rdif[DATA_W-1-i];
    end

    assign rsum  = cur_r + idx_r;
    assign rdif  = cur_r - idx_r;
    assign imm_z = {{(DATA_W-IMM_W){1'b0}}, imm};

    always_comb begin
        upd  = 1'b0;
        calc = cur;
        unique case (cmd)
            CMD_ACCESS: begin
                upd = 1'b1;
                case (mode)
                    MOD_INC:  calc = cur + 1'b1;
                    MOD_DEC:  calc = cur - 1'b1;
                    MOD_IADD: calc = cur + idx;
                    MOD_ISUB: calc = cur - idx;
                    MOD_RADD: calc = rsum_r;
                    MOD_RSUB: calc = rdif_r;
                    default:  upd  = 1'b0;
                endcase
            end
            CMD_ADDK: begin
                upd  = 1'b1;
                calc = cur + imm_z;
            end
            CMD_SUBK: begin
                upd  = 1'b1;
                calc = cur - imm_z;
            end
            default: upd = 1'b0;
        endcase
        nxt = wrap_hit ? wrap_to : calc;
    end
endmodule

// File: rtl/aux_cmp.sv
module aux_cmp
    import aux_addr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] ref_val,
    input  cmp_e              sel,
    output logic              res
);
    always_comb begin
        unique case (sel)
            CMP_EQ:  res = (cur == ref_val);
            CMP_LT:  res = (cur <  ref_val);
            CMP_GT:  res = (cur >  ref_val);
            default: res = (cur != ref_val);
        endcase
    end
endmodule

// File: rtl/aux_addr_unit.sv
module aux_addr_unit
    import aux_addr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NUM_AR = 8,
    parameter int IMM_W  = 8,
    localparam int PTR_W = $clog2(NUM_AR),
    localparam int CTL_W = 2 * (PTR_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0]               cmd,
    input  logic [2:0]               mode,
    input  logic [IMM_W-1:0]         imm,
    input  logic [PTR_W-1:0]         new_ptr,
    input  logic [DATA_W-1:0]        idx_val,
    input  logic [DATA_W-1:0]        cmp_val,
    input  logic [1:0]               cmp_sel,
    input  logic [CTL_W-1:0]         circ_ctrl,
    input  logic [DATA_W-1:0]        buf0_start,
    input  logic [DATA_W-1:0]        buf0_end,
    input  logic [DATA_W-1:0]        buf1_start,
    input  logic [DATA_W-1:0]        buf1_end,
    input  logic                     ld_en,
    input  logic [PTR_W-1:0]         ld_sel,
    input  logic [DATA_W-1:0]        ld_val,
    output logic [DATA_W-1:0]        addr_out,
    output logic                     tc_flag,
    output logic [PTR_W-1:0]         ptr_out,
    output logic [PTR_W-1:0]         ptr_bak,
    output logic [NUM_AR*DATA_W-1:0] ar_flat
);
    cmd_e              cmd_t;
    mod_e              mode_t;
    logic [PTR_W-1:0]  ptr_q, bak_q;
    logic              tc_q, cmp_res, wrap_hit, upd;
    logic [DATA_W-1:0] cur, wrap_to, nxt;

    assign cmd_t  = cmd_e'(cmd);
    assign mode_t = mod_e'(mode);
    assign cur    = ar_flat[ptr_q*DATA_W +: DATA_W];

    aux_circ #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_circ (
        .ptr(ptr_q), .cur(cur), .ctrl(circ_ctrl),
        .start0(buf0_start), .end0(buf0_end),
        .start1(buf1_start), .end1(buf1_end),
        .hit(wrap_hit), .wrap_to(wrap_to)
    );

    aux_step #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_step (
        .cmd(cmd_t), .mode(mode_t), .cur(cur), .idx(idx_val), .imm(imm),
        .wrap_hit(wrap_hit), .wrap_to(wrap_to), .upd(upd), .nxt(nxt)
    );

    aux_cmp #(.DATA_W(DATA_W)) u_cmp (
        .cur(cur), .ref_val(cmp_val), .sel(cmp_e'(cmp_sel)), .res(cmp_res)
    );

    for (genvar g = 0; g < NUM_AR; g++) begin : g_ar
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (ld_en && ld_sel == PTR_W'(g))
                q <= ld_val;
            else if (upd && ptr_q == PTR_W'(g))
                q <= nxt;
        end
        assign ar_flat[g*DATA_W +: DATA_W] = q;

        // R10: direct load wins over any modification of this register
        assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
            (ld_en && ld_sel == PTR_W'(g)) |=> (q == $past(ld_val)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            bak_q <= '0;
            tc_q  <= 1'b0;
        end else begin
            if (cmd_t == CMD_SETPTR) begin
                bak_q <= ptr_q;
                ptr_q <= new_ptr;
            end
            if (cmd_t == CMD_CMP)
                tc_q <= cmp_res;
        end
    end

    assign addr_out = cur;
    assign tc_flag  = tc_q;
    assign ptr_out  = ptr_q;
    assign ptr_bak  = bak_q;

    // R7: pointer change keeps the old pointer in the backup field
    assert_ptr_backup_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd4) |=> (ptr_bak == $past(ptr_out) && ptr_out == $past(new_ptr)));

    // R8: flag changes only on a compare command
    assert_tc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd != 3'd5) |=> $stable(tc_flag));

    // R11: access with no-change mode and no load keeps the address
    assert_no_change_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd1 && (mode == 3'd0 || mode == 3'd7) && !ld_en) |=> $stable(addr_out));

    // R9: a wrap hit on a modification reloads the buffer start
    assert_wrap_start_R9: assert property (@(posedge clk) disable iff (rst)
        (upd && wrap_hit && !ld_en) |=> (addr_out == $past(wrap_to)));
endmodule

// File: tb/aux_addr_unit_bench.sv
module aux_addr_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   cmd = 3'd0, mode = 3'd0, new_ptr = 3'd0, ld_sel = 3'd0;
    logic [7:0]   imm = 8'd0, circ_ctrl = 8'd0;
    logic [15:0]  idx_val = 16'd0, cmp_val = 16'd0, ld_val = 16'd0;
    logic [15:0]  buf0_start = 16'd0, buf0_end = 16'd0, buf1_start = 16'd0, buf1_end = 16'd0;
    logic [1:0]   cmp_sel = 2'd0;
    logic         ld_en = 1'b0;
    logic [15:0]  addr_out;
    logic         tc_flag;
    logic [2:0]   ptr_out, ptr_bak;
    logic [127:0] ar_flat;

    int checks = 0;
    int fails  = 0;

    logic [15:0] m_ar [8];
    logic [2:0]  m_ptr = 3'd0, m_bak = 3'd0;
    logic        m_tc = 1'b0;

    always #10 clk = ~clk;

    aux_addr_unit u_aux_addr_unit (
        .clk(clk), .rst(rst), .cmd(cmd), .mode(mode), .imm(imm), .new_ptr(new_ptr),
        .idx_val(idx_val), .cmp_val(cmp_val), .cmp_sel(cmp_sel), .circ_ctrl(circ_ctrl),
        .buf0_start(buf0_start), .buf0_end(buf0_end),
        .buf1_start(buf1_start), .buf1_end(buf1_end),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
        .addr_out(addr_out), .tc_flag(tc_flag), .ptr_out(ptr_out),
        .ptr_bak(ptr_bak), .ar_flat(ar_flat)
    );

    function automatic logic [15:0] rc_add(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] s;
        logic c = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            s[i] = a[i] ^ b[i] ^ c;
            c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        return s;
    endfunction

    function automatic logic [15:0] rc_sub(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] d;
        logic bw = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            d[i] = a[i] ^ b[i] ^ bw;
            bw = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & bw);
        end
        return d;
    endfunction

    task automatic check_state(input string tag);
        logic bad = 1'b0;
        checks++;
        for (int r = 0; r < 8; r++)
            if (ar_flat[r*16 +: 16] !== m_ar[r]) begin
                bad = 1'b1;
                $display("FAIL %s reg%0d actual=%h expected=%h", tag, r, ar_flat[r*16 +: 16], m_ar[r]);
            end
        if (ptr_out !== m_ptr || ptr_bak !== m_bak || tc_flag !== m_tc || addr_out !== m_ar[m_ptr]) begin
            bad = 1'b1;
            $display("FAIL %s ptr/bak/tc/addr actual=%0d/%0d/%0d/%h expected=%0d/%0d/%0d/%h",
                     tag, ptr_out, ptr_bak, tc_flag, addr_out, m_ptr, m_bak, m_tc, m_ar[m_ptr]);
        end
        if (bad) fails++;
    endtask

    task automatic step(input logic [2:0] c, input logic [2:0] md, input logic [7:0] im,
                        input logic [2:0] np, input logic [15:0] ix, input logic [15:0] cv,
                        input logic [1:0] cs, input logic le, input logic [2:0] ls,
                        input logic [15:0] lv, input string tag);
        logic [15:0] cur, calc;
        logic modv, h0, h1;
        @(negedge clk);
        cmd = c; mode = md; imm = im; new_ptr = np; idx_val = ix; cmp_val = cv;
        cmp_sel = cs; ld_en = le; ld_sel = ls; ld_val = lv;
        cur = m_ar[m_ptr]; calc = cur; modv = 1'b0;
        #1;
        if (c == 3'd1) begin
            checks++;
            if (addr_out !== cur) begin
                fails++;
                $display("FAIL R2 %s pre-update addr actual=%h expected=%h", tag, addr_out, cur);
            end
        end
        case (c)
            3'd1: begin
                modv = (md != 3'd0 && md != 3'd7);
                case (md)
                    3'd1: calc = cur + 16'd1;
                    3'd2: calc = cur - 16'd1;
                    3'd3: calc = cur + ix;
                    3'd4: calc = cur - ix;
                    3'd5: calc = rc_add(cur, ix);
                    3'd6: calc = rc_sub(cur, ix);
                    default: calc = cur;
                endcase
            end
            3'd2: begin modv = 1'b1; calc = cur + {8'd0, im}; end
            3'd3: begin modv = 1'b1; calc = cur - {8'd0, im}; end
            default: ;
        endcase
        h0 = circ_ctrl[3] && circ_ctrl[2:0] == m_ptr && cur == buf0_end;
        h1 = circ_ctrl[7] && circ_ctrl[6:4] == m_ptr && cur == buf1_end;
        if (modv) m_ar[m_ptr] = h0 ? buf0_start : (h1 ? buf1_start : calc);
        if (c == 3'd5)
            case (cs)
                2'd0: m_tc = (cur == cv);
                2'd1: m_tc = (cur < cv);
                2'd2: m_tc = (cur > cv);
                default: m_tc = (cur != cv);
            endcase
        if (c == 3'd4) begin m_bak = m_ptr; m_ptr = np; end
        if (le) m_ar[ls] = lv;
        @(negedge clk);
        check_state(tag);
        cmd = 3'd0; ld_en = 1'b0;
    endtask

    task automatic acc(input logic [2:0] md, input logic [15:0] ix, input string tag);
        step(3'd1, md, 8'd0, 3'd0, ix, 16'd0, 2'd0, 1'b0, 3'd0, 16'd0, tag);
    endtask

    task automatic load(input logic [2:0] r, input logic [15:0] v, input string tag);
        step(3'd0, 3'd0, 8'd0, 3'd0, 16'd0, 16'd0, 2'd0, 1'b1, r, v, tag);
    endtask

    task automatic setp(input logic [2:0] p, input string tag);
        step(3'd4, 3'd0, 8'd0, p, 16'd0, 16'd0, 2'd0, 1'b0, 3'd0, 16'd0, tag);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] ivals [4];
        logic [15:0] init  [8];
        ivals[0] = 16'h0008; ivals[1] = 16'h0001; ivals[2] = 16'hFFFF; ivals[3] = 16'h8000;
        init[0] = 16'hFFFF; init[1] = 16'h0000; init[2] = 16'h0100; init[3] = 16'h8001;
        init[4] = 16'h7FFF; init[5] = 16'h0060; init[6] = 16'h1234; init[7] = 16'hFFFE;
        for (int r = 0; r < 8; r++) m_ar[r] = 16'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_state("R1 reset");

        for (int r = 0; r < 8; r++) load(3'(r), init[r], "R10 load");

        // sweep every pointer and every mode; R3 R4 R5 R11
        for (int p = 0; p < 8; p++) begin
            setp(3'(p), "R7 pointer");
            for (int md = 0; md < 8; md++)
                acc(3'(md), ivals[(md + p) % 4], "R3 R4 R5 R11 mode sweep");
        end

        // idle and unused commands change nothing (R11)
        step(3'd6, 3'd1, 8'hFF, 3'd0, 16'd5, 16'd0, 2'd0, 1'b0, 3'd0, 16'd0, "R11 unused cmd");
        step(3'd7, 3'd1, 8'hFF, 3'd0, 16'd5, 16'd0, 2'd0, 1'b0, 3'd0, 16'd0, "R11 unused cmd");

        // reverse-carry walk from a base with a half-size index (R5)
        setp(3'd5, "R7 pointer");
        load(3'd5, 16'h0060, "R10 load");
        for (int k = 0; k < 9; k++) acc(3'd5, 16'h0008, "R5 reverse add walk");
        for (int k = 0; k < 9; k++) acc(3'd6, 16'h0008, "R5 reverse sub walk");

        // immediate add and subtract with wrap (R6)
        load(3'd5, 16'hFFF0, "R10 load");
        step(3'd2, 3'd0, 8'hFF, 3'd0, 16'd0, 16'd0, 2'd0, 1'b0, 3'd0, 16'd0, "R6 add imm wrap");
        step(3'd3, 3'd0, 8'hF0, 3'd0, 16'd0, 16'd0, 2'd0, 1'b0, 3'd0, 16'd0, "R6 sub imm wrap");
        step(3'd3, 3'd0, 8'h01, 3'd0, 16'd0, 16'd0, 2'd0, 1'b0, 3'd0, 16'd0, "R6 sub imm");

        // compare sweep (R8)
        load(3'd5, 16'h0500, "R10 load");
        for (int cs = 0; cs < 4; cs++)
            for (int d = 0; d < 3; d++) begin
                step(3'd5, 3'd0, 8'd0, 3'd0, 16'd0, 16'h04FF + 16'(d), 2'(cs), 1'b0, 3'd0, 16'd0, "R8 compare");
                acc(3'd0, 16'd0, "R8 flag holds");
            end

        // circular buffer 0 on register 2 (R9)
        circ_ctrl = 8'h0A; buf0_start = 16'h0200; buf0_end = 16'h0203;
        setp(3'd2, "R7 pointer");
        load(3'd2, 16'h0200, "R10 load");
        for (int k = 0; k < 5; k++) acc(3'd1, 16'd0, "R9 circular inc");
        load(3'd2, 16'h0203, "R10 load");
        acc(3'd2, 16'd0, "R9 wrap on decrement at end");
        load(3'd2, 16'h0203, "R10 load");
        step(3'd2, 3'd0, 8'h10, 3'd0, 16'd0, 16'd0, 2'd0, 1'b0, 3'd0, 16'd0, "R9 wrap on add imm");

        // buffer 1 on register 5 with index step (R9)
        circ_ctrl = 8'hDA; buf1_start = 16'h0400; buf1_end = 16'h0410;
        setp(3'd5, "R7 pointer");
        load(3'd5, 16'h0400, "R10 load");
        for (int k = 0; k < 4; k++) acc(3'd3, 16'h0008, "R9 circular index");

        // both buffers on register 2: buffer 0 first (R9)
        circ_ctrl = 8'hAA; buf1_start = 16'h0300; buf1_end = 16'h0203;
        setp(3'd2, "R7 pointer");
        load(3'd2, 16'h0203, "R10 load");
        acc(3'd1, 16'd0, "R9 buffer 0 priority");
        // disabled buffer: no wrap
        circ_ctrl = 8'h02;
        load(3'd2, 16'h0203, "R10 load");
        acc(3'd1, 16'd0, "R9 disabled no wrap");

        // load against modify (R10)
        step(3'd1, 3'd1, 8'd0, 3'd0, 16'd0, 16'd0, 2'd0, 1'b1, 3'd2, 16'h0ABC, "R10 load beats modify");
        step(3'd1, 3'd1, 8'd0, 3'd0, 16'd0, 16'd0, 2'd0, 1'b1, 3'd3, 16'h5555, "R10 load other reg");

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule